// File: doc/BRIEF.md
# Two-Level Address Translation Buffer with Hit-Under-Miss

This block sits in series on a command path and turns virtual addresses into physical ones. Each command carries a virtual address, a context identifier and a few side-band attribute bits. The block accepts at most one command per cycle. It looks the page up in a small micro-TLB and, in the same cycle, in a larger main TLB. A command that hits either level leaves one cycle later. It carries the physical page, the unchanged 4 KB page offset, and attributes that the matching entry may rewrite.

When both levels miss, the command is parked in one of a few miss slots and a translation request goes to an external translation controller. Later commands that hit keep flowing while requests are outstanding. A second miss to a page that is already being fetched waits in a slot of its own and sends no request.

When the controller answers, the main TLB is filled and every parked command for that page and context is released, one per cycle in slot order. An error answer releases the parked commands marked as faulted and fills no entry. A main-TLB hit copies the entry into the micro-TLB. Both levels replace their entries round-robin.

Top module: `tlb_unit`

## Requirements
- R1: After reset, out_valid and req_valid are 0 and in_ready is 1 while rsp_valid is 0.
- R2: A command accepted (in_valid and in_ready high at a clock edge) that hits either TLB level appears on the outputs after that edge. It has out_valid=1, out_fault=0, out_paddr = {translated page, input address bits 11:0} and out_ctx = in_ctx. Hits accepted on consecutive cycles come out on consecutive cycles.
- R3: The context identifier is part of the match. A known page presented with a different context misses.
- R4: An accepted command that misses both levels is not forwarded. After the edge, req_valid=1 for one cycle, with req_vpn = address bits 31:12, req_ctx = the context, and req_tag = the index of the lowest free miss slot.
- R5: An accepted miss whose page and context match a slot that is still waiting for a response is parked in the lowest free slot and raises no request.
- R6: While misses are outstanding, a command that hits is accepted and forwarded as in R2.
- R7: There are 4 miss slots. When all 4 are occupied, a missing command holds in_ready at 0 and produces no output and no request. A hitting command is still accepted. Once a slot is freed, the miss is accepted and takes that slot.
- R8: A response (rsp_valid=1, rsp_tag = a slot waiting on its own request) releases every waiting slot with the same page and context. The released commands appear one per cycle in ascending slot order, the first one after the second edge following the response cycle. in_ready is 0 during the response cycle and while released commands remain.
- R9: An entry filled with rsp_aen=1 replaces the command's attributes with rsp_attr. With rsp_aen=0 the command's own in_attr passes through.
- R10: A response with rsp_err=1 releases its commands with out_fault=1, out_paddr = the original virtual address and out_attr = the command's own attributes. It allocates no entry, so a later access to that page misses again.
- R11: The 64-entry main TLB replaces round-robin. After 64 further fills, a page that was filled and never looked up again misses, while a page filled 63 fills ago still hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interconnect clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Command accepted this cycle if in_valid |
| in_vaddr | input | 32 | Virtual address |
| in_ctx | input | 4 | Context identifier |
| in_attr | input | 4 | Side-band attributes |
| out_valid | output | 1 | Translated or faulted command present |
| out_paddr | output | 32 | Physical address (virtual address when faulted) |
| out_ctx | output | 4 | Context identifier of the command |
| out_attr | output | 4 | Attributes, possibly rewritten |
| out_fault | output | 1 | Translation failed |
| req_valid | output | 1 | Translation request pulse |
| req_tag | output | 2 | Slot tag of the request |
| req_vpn | output | 20 | Virtual page requested |
| req_ctx | output | 4 | Context requested |
| rsp_valid | input | 1 | Translation response present |
| rsp_tag | input | 2 | Tag being answered |
| rsp_ppn | input | 20 | Physical page |
| rsp_aen | input | 1 | 1 = rewrite attributes with rsp_attr |
| rsp_attr | input | 4 | Replacement attributes |
| rsp_err | input | 1 | 1 = translation failed |

## Verification
The properties assume that the controller answers only tags that carry an outstanding request, answers each of them exactly once, and holds rsp_valid for single cycles. They also assume the downstream side always accepts output. The stimulus keeps a model of the occupied slots and raises a response only for a slot it knows is waiting on its own request, one cycle at a time. It lets released commands drain before it presents new input, which matches the stall the block applies itself. The main-TLB replacement check relies on the bench never looking up the victim page after its fill, so that the page cannot be held in the micro-TLB.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int CTX_W  = 4;
    localparam int ATTR_W = 4;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = PA_W - OFF_W;

    typedef struct packed {
        logic              valid;
        logic [VPN_W-1:0]  vpn;
        logic [CTX_W-1:0]  ctx;
        logic [PPN_W-1:0]  ppn;
        logic              aen;
        logic [ATTR_W-1:0] attr;
    } xlat_t;

    typedef struct packed {
        logic              valid;
        logic              rdy;
        logic              err;
        logic [VPN_W-1:0]  vpn;
        logic [OFF_W-1:0]  off;
        logic [CTX_W-1:0]  ctx;
        logic [ATTR_W-1:0] attr;
        logic [PPN_W-1:0]  ppn;
        logic              aen;
        logic [ATTR_W-1:0] rattr;
    } slot_t;
endpackage

// File: rtl/tlb_cam.sv
module tlb_cam
    import tlb_pkg::*;
#(
    parameter int N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [CTX_W-1:0]  lk_ctx,
    output logic              lk_hit,
    output logic [PPN_W-1:0]  lk_ppn,
    output logic              lk_aen,
    output logic [ATTR_W-1:0] lk_attr,
    input  logic              wr_en,
    input  xlat_t             wr_ent
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    typedef struct packed {
        xlat_t [N-1:0] ent;
        logic [PW-1:0] ptr;
    } cam_st_t;

    cam_st_t st_d, st_q;

    always_comb begin
        lk_hit  = 1'b0;
        lk_ppn  = '0;
        lk_aen  = 1'b0;
        lk_attr = '0;
        for (int i = 0; i < N; i++) begin
            if (!lk_hit && st_q.ent[i].valid &&
                st_q.ent[i].vpn == lk_vpn && st_q.ent[i].ctx == lk_ctx) begin
                lk_hit  = 1'b1;
                lk_ppn  = st_q.ent[i].ppn;
                lk_aen  = st_q.ent[i].aen;
                lk_attr = st_q.ent[i].attr;
            end
        end
        st_d = st_q;
        if (wr_en) begin
            st_d.ent[st_q.ptr] = wr_ent;
            st_d.ptr = (st_q.ptr == PW'(N - 1)) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tlb_park.sv
module tlb_park
    import tlb_pkg::*;
#(
    parameter int SLOTS = 4,
    localparam int TW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              al_en,
    input  logic [VA_W-1:0]   al_vaddr,
    input  logic [CTX_W-1:0]  al_ctx,
    input  logic [ATTR_W-1:0] al_attr,
    output logic              pend_match,
    output logic              has_free,
    output logic [TW-1:0]     free_idx,
    input  logic              rsp_valid,
    input  logic [TW-1:0]     rsp_tag,
    input  logic [PPN_W-1:0]  rsp_ppn,
    input  logic              rsp_aen,
    input  logic [ATTR_W-1:0] rsp_attr,
    input  logic              rsp_err,
    output logic [VPN_W-1:0]  key_vpn,
    output logic [CTX_W-1:0]  key_ctx,
    output logic              any_rdy,
    output logic [PA_W-1:0]   dr_paddr,
    output logic [CTX_W-1:0]  dr_ctx,
    output logic [ATTR_W-1:0] dr_attr,
    output logic              dr_fault
);
    typedef struct packed {
        slot_t [SLOTS-1:0] s;
    } park_st_t;

    park_st_t st_d, st_q;
    logic [TW-1:0]    dsel;
    logic [VPN_W-1:0] al_vpn;
    slot_t            dslot;

    always_comb begin
        al_vpn     = al_vaddr[VA_W-1:OFF_W];
        pend_match = 1'b0;
        has_free   = 1'b0;
        free_idx   = '0;
        any_rdy    = 1'b0;
        dsel       = '0;
        for (int i = SLOTS - 1; i >= 0; i--) begin
            if (st_q.s[i].valid && !st_q.s[i].rdy &&
                st_q.s[i].vpn == al_vpn && st_q.s[i].ctx == al_ctx)
                pend_match = 1'b1;
            if (!st_q.s[i].valid) begin
                has_free = 1'b1;
                free_idx = TW'(i);
            end
            if (st_q.s[i].valid && st_q.s[i].rdy) begin
                any_rdy = 1'b1;
                dsel    = TW'(i);
            end
        end
        key_vpn  = st_q.s[rsp_tag].vpn;
        key_ctx  = st_q.s[rsp_tag].ctx;
        dslot    = st_q.s[dsel];
        dr_fault = dslot.err;
        dr_ctx   = dslot.ctx;
        dr_paddr = dslot.err ? PA_W'({dslot.vpn, dslot.off}) : {dslot.ppn, dslot.off};
        dr_attr  = (!dslot.err && dslot.aen) ? dslot.rattr : dslot.attr;

        st_d = st_q;
        if (rsp_valid) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (st_q.s[i].valid && !st_q.s[i].rdy &&
                    st_q.s[i].vpn == key_vpn && st_q.s[i].ctx == key_ctx) begin
                    st_d.s[i].rdy   = 1'b1;
                    st_d.s[i].err   = rsp_err;
                    st_d.s[i].ppn   = rsp_ppn;
                    st_d.s[i].aen   = rsp_aen;
                    st_d.s[i].rattr = rsp_attr;
                end
            end
        end
        if (any_rdy) st_d.s[dsel] = '0;
        if (al_en) begin
            st_d.s[free_idx]       = '0;
            st_d.s[free_idx].valid = 1'b1;
            st_d.s[free_idx].vpn   = al_vpn;
            st_d.s[free_idx].off   = al_vaddr[OFF_W-1:0];
            st_d.s[free_idx].ctx   = al_ctx;
            st_d.s[free_idx].attr  = al_attr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/tlb_unit.sv
module tlb_unit
    import tlb_pkg::*;
#(
    parameter int UTLB_N = 8,
    parameter int MTLB_N = 64,
    parameter int SLOTS  = 4,
    localparam int TW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [VA_W-1:0]   in_vaddr,
    input  logic [CTX_W-1:0]  in_ctx,
    input  logic [ATTR_W-1:0] in_attr,
    output logic              out_valid,
    output logic [PA_W-1:0]   out_paddr,
    output logic [CTX_W-1:0]  out_ctx,
    output logic [ATTR_W-1:0] out_attr,
    output logic              out_fault,
    output logic              req_valid,
    output logic [TW-1:0]     req_tag,
    output logic [VPN_W-1:0]  req_vpn,
    output logic [CTX_W-1:0]  req_ctx,
    input  logic              rsp_valid,
    input  logic [TW-1:0]     rsp_tag,
    input  logic [PPN_W-1:0]  rsp_ppn,
    input  logic              rsp_aen,
    input  logic [ATTR_W-1:0] rsp_attr,
    input  logic              rsp_err
);
    typedef struct packed {
        logic              out_valid;
        logic [PA_W-1:0]   out_paddr;
        logic [CTX_W-1:0]  out_ctx;
        logic [ATTR_W-1:0] out_attr;
        logic              out_fault;
        logic              req_valid;
        logic [TW-1:0]     req_tag;
        logic [VPN_W-1:0]  req_vpn;
        logic [CTX_W-1:0]  req_ctx;
    } top_st_t;

    top_st_t st_d, st_q;

    logic              u_hit, m_hit, lk_hit, acc, miss_acc, u_wr, m_wr;
    logic [PPN_W-1:0]  u_ppn, m_ppn, hit_ppn;
    logic              u_aen, m_aen, hit_aen;
    logic [ATTR_W-1:0] u_attr, m_attr, hit_attr;
    xlat_t             u_wr_ent, m_wr_ent;
    logic              pend_match, park_free, park_rdy, dr_fault;
    logic [TW-1:0]     free_idx;
    logic [VPN_W-1:0]  key_vpn, in_vpn;
    logic [CTX_W-1:0]  key_ctx, dr_ctx;
    logic [PA_W-1:0]   dr_paddr;
    logic [ATTR_W-1:0] dr_attr;

    assign in_vpn = in_vaddr[VA_W-1:OFF_W];

    tlb_cam #(.N(UTLB_N)) u_utlb (
        .clk(clk), .rst_n(rst_n), .lk_vpn(in_vpn), .lk_ctx(in_ctx),
        .lk_hit(u_hit), .lk_ppn(u_ppn), .lk_aen(u_aen), .lk_attr(u_attr),
        .wr_en(u_wr), .wr_ent(u_wr_ent));

    tlb_cam #(.N(MTLB_N)) u_mtlb (
        .clk(clk), .rst_n(rst_n), .lk_vpn(in_vpn), .lk_ctx(in_ctx),
        .lk_hit(m_hit), .lk_ppn(m_ppn), .lk_aen(m_aen), .lk_attr(m_attr),
        .wr_en(m_wr), .wr_ent(m_wr_ent));

    tlb_park #(.SLOTS(SLOTS)) u_park (
        .clk(clk), .rst_n(rst_n), .al_en(miss_acc), .al_vaddr(in_vaddr),
        .al_ctx(in_ctx), .al_attr(in_attr), .pend_match(pend_match),
        .has_free(park_free), .free_idx(free_idx), .rsp_valid(rsp_valid),
        .rsp_tag(rsp_tag), .rsp_ppn(rsp_ppn), .rsp_aen(rsp_aen),
        .rsp_attr(rsp_attr), .rsp_err(rsp_err), .key_vpn(key_vpn),
        .key_ctx(key_ctx), .any_rdy(park_rdy), .dr_paddr(dr_paddr),
        .dr_ctx(dr_ctx), .dr_attr(dr_attr), .dr_fault(dr_fault));

    always_comb begin
        lk_hit   = u_hit | m_hit;
        hit_ppn  = u_hit ? u_ppn  : m_ppn;
        hit_aen  = u_hit ? u_aen  : m_aen;
        hit_attr = u_hit ? u_attr : m_attr;
        in_ready = !park_rdy && !rsp_valid && (lk_hit || park_free);
        acc      = in_valid && in_ready;
        miss_acc = acc && !lk_hit;
        u_wr     = acc && !u_hit && m_hit;
        u_wr_ent = '{valid: 1'b1, vpn: in_vpn, ctx: in_ctx, ppn: m_ppn,
                     aen: m_aen, attr: m_attr};
        m_wr     = rsp_valid && !rsp_err;
        m_wr_ent = '{valid: 1'b1, vpn: key_vpn, ctx: key_ctx, ppn: rsp_ppn,
                     aen: rsp_aen, attr: rsp_attr};

        st_d = '0;
        if (acc && lk_hit) begin
            st_d.out_valid = 1'b1;
            st_d.out_paddr = {hit_ppn, in_vaddr[OFF_W-1:0]};
            st_d.out_ctx   = in_ctx;
            st_d.out_attr  = hit_aen ? hit_attr : in_attr;
        end else if (park_rdy) begin
            st_d.out_valid = 1'b1;
            st_d.out_paddr = dr_paddr;
            st_d.out_ctx   = dr_ctx;
            st_d.out_attr  = dr_attr;
            st_d.out_fault = dr_fault;
        end
        if (miss_acc && !pend_match) begin
            st_d.req_valid = 1'b1;
            st_d.req_tag   = free_idx;
            st_d.req_vpn   = in_vpn;
            st_d.req_ctx   = in_ctx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.out_valid;
    assign out_paddr = st_q.out_paddr;
    assign out_ctx   = st_q.out_ctx;
    assign out_attr  = st_q.out_attr;
    assign out_fault = st_q.out_fault;
    assign req_valid = st_q.req_valid;
    assign req_tag   = st_q.req_tag;
    assign req_vpn   = st_q.req_vpn;
    assign req_ctx   = st_q.req_ctx;
endmodule

// File: rtl/tlb_unit_chk.sv
module tlb_unit_chk
    import tlb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [OFF_W-1:0] in_off,
    input logic [CTX_W-1:0] in_ctx,
    input logic             hit,
    input logic             any_rdy,
    input logic             has_free,
    input logic             rsp_valid,
    input logic             out_valid,
    input logic [OFF_W-1:0] out_off,
    input logic [CTX_W-1:0] out_ctx,
    input logic             out_fault,
    input logic             req_valid
);
    AST_HIT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && hit |=> out_valid && !out_fault && out_off == $past(in_off)); // R2
    AST_HIT_CTX: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && hit |=> out_ctx == $past(in_ctx)); // R3
    AST_MISS_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !hit |=> !out_valid); // R4
    AST_REQ_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !out_valid); // R4
    AST_HIT_UNDER_MISS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && hit && !any_rdy && !rsp_valid |-> in_ready); // R6
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && !hit && !has_free |-> !in_ready); // R7
    AST_RSP_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid || any_rdy |-> !in_ready); // R8
endmodule

bind tlb_unit tlb_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_off(in_vaddr[tlb_pkg::OFF_W-1:0]), .in_ctx(in_ctx), .hit(lk_hit),
    .any_rdy(park_rdy), .has_free(park_free), .rsp_valid(rsp_valid),
    .out_valid(out_valid), .out_off(out_paddr[tlb_pkg::OFF_W-1:0]),
    .out_ctx(out_ctx), .out_fault(out_fault), .req_valid(req_valid));

// File: tb/sim_tlb_unit.sv
`timescale 1ns/1ps
module sim_tlb_unit;
    logic        clk = 0, rst_n = 0;
    logic        in_valid = 0, in_ready;
    logic [31:0] in_vaddr = 0;
    logic [3:0]  in_ctx = 0, in_attr = 0;
    logic        out_valid, out_fault, req_valid;
    logic [31:0] out_paddr;
    logic [3:0]  out_ctx, out_attr, req_ctx;
    logic [1:0]  req_tag;
    logic [19:0] req_vpn;
    logic        rsp_valid = 0, rsp_aen = 0, rsp_err = 0;
    logic [1:0]  rsp_tag = 0;
    logic [19:0] rsp_ppn = 0;
    logic [3:0]  rsp_attr = 0;

    int nchk = 0, nerr = 0;
    bit done = 0;
    bit acc;
    bit        sv[4];
    logic [31:0] sva[4];
    logic [3:0]  sctx[4], sattr[4];

    always #10 clk = ~clk;

    tlb_unit u0 (.*);

    function automatic logic [19:0] mppn(logic [19:0] v, logic [3:0] c);
        return v * 20'd3 + 20'(c);
    endfunction

    task automatic chk(input bit ok, input string r, input logic [63:0] a, input logic [63:0] e);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s act=%0h exp=%0h", r, a, e);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    endtask

    task automatic step();
        #1 acc = in_valid && in_ready;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int lowest_free();
        for (int i = 0; i < 4; i++) if (!sv[i]) return i;
        return -1;
    endfunction

    // kind: 0 hit, 1 miss with request, 2 miss merged into a pending page
    task automatic issue(input logic [31:0] va, input logic [3:0] c, input logic [3:0] at,
                         input int kind, input string r);
        int f;
        logic [19:0] v;
        logic [31:0] exp_pa;
        logic [3:0]  exp_at;
        v = va[31:12];
        f = lowest_free();
        in_valid = 1; in_vaddr = va; in_ctx = c; in_attr = at;
        step();
        in_valid = 0;
        chk(acc, {r, " accepted"}, acc, 1);
        if (kind == 0) begin
            exp_pa = {mppn(v, c), va[11:0]};
            exp_at = v[0] ? (v[3:0] ^ c) : at;
            chk(out_valid == 1, {r, " out_valid"}, out_valid, 1);
            chk(out_paddr == exp_pa, {r, " out_paddr"}, out_paddr, exp_pa);
            chk(out_ctx == c, {r, " out_ctx"}, out_ctx, c);
            chk(out_attr == exp_at, {r, " out_attr R9"}, out_attr, exp_at);
            chk(out_fault == 0, {r, " out_fault"}, out_fault, 0);
        end else begin
            chk(out_valid == 0, {r, " miss not forwarded R4"}, out_valid, 0);
            if (kind == 1) begin
                chk(req_valid == 1, {r, " req_valid R4"}, req_valid, 1);
                chk(req_tag == f[1:0], {r, " req_tag R4"}, req_tag, f);
                chk(req_vpn == v, {r, " req_vpn R4"}, req_vpn, v);
                chk(req_ctx == c, {r, " req_ctx R4"}, req_ctx, c);
            end else begin
                chk(req_valid == 0, {r, " merged miss no request R5"}, req_valid, 0);
            end
            sv[f] = 1; sva[f] = va; sctx[f] = c; sattr[f] = at;
        end
    endtask

    task automatic resolve(input int tag);
        logic [19:0] v;
        logic [3:0]  c;
        bit          e;
        logic [31:0] exp_pa;
        logic [3:0]  exp_at;
        bit          m[4];
        v = sva[tag][31:12];
        c = sctx[tag];
        e = (c == 4'hF);
        for (int i = 0; i < 4; i++) m[i] = sv[i] && sva[i][31:12] == v && sctx[i] == c;
        rsp_valid = 1; rsp_tag = tag[1:0]; rsp_ppn = mppn(v, c);
        rsp_aen = v[0]; rsp_attr = v[3:0] ^ c; rsp_err = e;
        #1 chk(in_ready == 0, "R8 stall during response", in_ready, 0);
        step();
        rsp_valid = 0;
        chk(out_valid == 0, "R8 no output in response cycle", out_valid, 0);
        for (int i = 0; i < 4; i++) begin
            if (m[i]) begin
                #1 chk(in_ready == 0, "R8 stall while draining", in_ready, 0);
                step();
                exp_pa = e ? sva[i] : {mppn(v, c), sva[i][11:0]};
                exp_at = (!e && v[0]) ? (v[3:0] ^ c) : sattr[i];
                chk(out_valid == 1, "R8 release valid", out_valid, 1);
                chk(out_paddr == exp_pa, e ? "R10 fault paddr" : "R8 release paddr", out_paddr, exp_pa);
                chk(out_ctx == c, "R8 release ctx", out_ctx, c);
                chk(out_attr == exp_at, e ? "R10 fault attr" : "R9 release attr", out_attr, exp_at);
                chk(out_fault == e, e ? "R10 fault flag" : "R8 no fault", out_fault, e);
                sv[i] = 0;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] pa, pb, pz;
        for (int i = 0; i < 4; i++) sv[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        chk(out_valid == 0, "R1 out_valid", out_valid, 0);
        chk(req_valid == 0, "R1 req_valid", req_valid, 0);
        chk(in_ready == 1, "R1 in_ready", in_ready, 1);

        pa = 32'h0001_2345;   // even page: attributes pass through
        pb = 32'h0003_3000;   // odd page: attributes rewritten
        issue(pa, 4'd1, 4'h2, 1, "R4 first miss");
        resolve(0);
        for (int k = 0; k < 8; k++)
            issue({pa[31:12], 12'(k * 12'h111)}, 4'd1, 4'(k), 0, "R2 back-to-back hit");

        issue(pa, 4'd2, 4'h0, 1, "R3 other context misses");
        resolve(0);

        issue(pb, 4'd1, 4'h5, 1, "R6 miss B");
        issue(pb | 32'h10, 4'd1, 4'h6, 2, "R5 merge B");
        issue(pa | 32'h7, 4'd1, 4'h9, 0, "R6 hit under miss");
        issue(32'h0004_4100, 4'd3, 4'h1, 1, "R6 miss C");
        issue(pa, 4'd2, 4'hC, 0, "R6 hit under two misses");
        resolve(2);
        resolve(0);
        for (int k = 0; k < 4; k++)
            issue(pb | 32'(k), 4'd1, 4'(k * 3), 0, "R9 rewritten attributes");

        for (int k = 0; k < 4; k++)
            issue(32'h0010_0000 + 32'(k << 12), 4'd4, 4'h3, 1, "R7 fill slots");
        in_valid = 1; in_vaddr = 32'h0020_0000; in_ctx = 4'd4; in_attr = 4'h1;
        step();
        in_valid = 0;
        chk(acc == 0, "R7 miss stalls when full", acc, 0);
        chk(out_valid == 0, "R7 no output while stalled", out_valid, 0);
        chk(req_valid == 0, "R7 no request while stalled", req_valid, 0);
        issue(pa | 32'h20, 4'd1, 4'h4, 0, "R7 hit accepted when full");
        resolve(1);
        issue(32'h0020_0000, 4'd4, 4'h1, 1, "R7 miss takes freed slot");
        resolve(0);
        resolve(2);
        resolve(3);
        resolve(1);

        issue(32'h0005_5ABC, 4'hF, 4'h7, 1, "R10 miss to faulting page");
        resolve(0);
        issue(32'h0005_5ABC, 4'hF, 4'h7, 1, "R10 no entry after fault");
        resolve(0);

        pz = 32'h0700_0000;
        issue(pz, 4'd5, 4'h0, 1, "R11 victim fill");
        resolve(0);
        for (int k = 1; k <= 64; k++) begin
            issue(32'h0800_0000 + 32'(k << 12), 4'd5, 4'h0, 1, "R11 sweep fill");
            resolve(0);
        end
        issue(32'h0800_1000, 4'd5, 4'h8, 0, "R11 fill 63 ago still hits");
        issue(pz | 32'h44, 4'd5, 4'h8, 1, "R11 oldest entry replaced");
        resolve(0);

        finish_run();
    end
endmodule